// File: doc/BRIEF.md
# Buffered Strobe-Driven Host Bus Adapter

This block lets a host processor reach an internal 16-bit register file and a shared RAM over a strobe-driven bus with buffered, latched signalling. An access begins when the active-low select and strobe are both asserted. At that point the adapter captures the direction, the RAM/register target, the write data and the address. It performs the internal access and answers with a ready handshake. The read and write data buses are separate ports.

Strap inputs change how the bus signals are read. One strap picks whole 16-bit words or byte transfers. A polarity strap flips the sense of the direction pin in word mode and of the byte-select pin in byte mode. A byte-order strap says which half of a word travels first. A wait strap picks between two timings. In nonzero-wait timing, ready means read data is on the bus or the write has finished. In zero-wait timing, the host releases the strobe at once, and ready then shows that the latched access is being completed inside the block. A further strap makes the address latch either capture once at the start of the access or follow the address pins for as long as the strobe is held.

In byte mode the first byte of a write is parked in a holding register, and the word is written only when the second byte arrives. The first byte of a read fetches the whole word. The second byte then comes from that snapshot, so both halves always belong to the same word.

Top module: `hostbus_adapter`

## Requirements
- R1: No access starts unless `sel_ni` and `strb_ni` are both low in the same clock. With only one of them low, `ready_o` stays low and no storage changes.
- R2: In nonzero-wait timing (`zw_ni`=1), when the access start is sampled at clock edge k, `ready_o` is high after edge k+1 and holds the read data on `rdata_o`. It stays high until the edge at which the strobe is seen released, and falls after that edge.
- R3: In zero-wait timing (`zw_ni`=0), `ready_o` stays low while the strobe is held. When the release is sampled at edge m, `ready_o` is high after edge m for ZW_CYC cycles and then falls. Read data is on `rdata_o` once `ready_o` has fallen.
- R4: `mem_i`=1 targets the RAM (all AW address bits). `mem_i`=0 targets the register file (the low RAW address bits). The two stores are distinct.
- R5: In word mode (`wide_i`=1), `rw_i`=1 means read when `pol_i`=1, and `rw_i`=0 means read when `pol_i`=0.
- R6: In byte mode (`wide_i`=0), `rw_i`=1 means read and 0 means write, whatever the value of `pol_i`.
- R7: In byte mode, the upper byte is selected by `bsel_i`=1 when `pol_i`=0, and by `bsel_i`=0 when `pol_i`=1. Byte data travels on bits [7:0].
- R8: In byte mode, `border_i`=1 makes the upper byte the first of a pair, and 0 makes the lower byte first. A first-byte write leaves the stored word unchanged. The second-byte write stores both bytes.
- R9: A first-byte read fetches the whole word. The following second-byte read returns the other half of that fetched word, even if the stored word changed in between.
- R10: `border_i` has no effect in word mode.
- R11: With `alat_transp_i`=0, the access uses the address present when it started. With `alat_transp_i`=1, in zero-wait timing it uses the address sampled on the last clock the strobe was held.
- R12: After reset, `ready_o` and `rdata_o` are 0 and every register-file word reads 0.
- R13: A byte-mode read drives the byte on `rdata_o[7:0]` and zeros on `rdata_o[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Block select, active low |
| strb_ni | input | 1 | Transfer strobe, active low |
| rw_i | input | 1 | Direction; meaning set by `wide_i` and `pol_i` |
| mem_i | input | 1 | 1 = RAM, 0 = register file |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data (byte mode uses [7:0]) |
| rdata_o | output | 16 | Read data |
| ready_o | output | 1 | Handshake to host |
| wide_i | input | 1 | 1 = word transfers, 0 = byte transfers |
| pol_i | input | 1 | Polarity strap for direction / byte select |
| bsel_i | input | 1 | Byte select in byte mode |
| border_i | input | 1 | Byte order: 1 = upper byte first |
| zw_ni | input | 1 | 0 = zero-wait timing, 1 = nonzero-wait |
| alat_transp_i | input | 1 | 1 = address latch follows pins while strobed |

## Verification
A sequencer stuck in the wrong state shows at once in the ready timing. Ready arrives a cycle early or late, or it never falls after the strobe is released, and the next access also goes wrong. A stale or wrong byte-holding register stays hidden until the second byte of a pair. It then shows up as a wrong half in a later word readback, or in the second byte of a read. Decoding the direction or the byte select the wrong way leaves writes that never land, or halves that come back swapped, on the next readback of that address.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_HOLD,
    ST_ZWAIT,
    ST_ZBUSY
  } hb_state_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode (
  input  logic wide_i,
  input  logic pol_i,
  input  logic border_i,
  input  logic rw_i,
  input  logic bsel_i,
  output logic read_o,
  output logic msb_o,
  output logic first_o
);
  // word mode with low polarity inverts direction sense
  assign read_o  = (wide_i && !pol_i) ? !rw_i : rw_i;
  assign msb_o   = pol_i ? !bsel_i : bsel_i;
  assign first_o = (msb_o == border_i);
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int ZW_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      act_i,
  input  logic      zw_ni,
  output logic      start_o,
  output logic      exec_o,
  output logic      ready_o,
  output hb_state_e state_o
);
  localparam int CW = (ZW_CYC > 1) ? $clog2(ZW_CYC) : 1;

  hb_state_e state_q, state_d;
  logic act_q;
  logic [CW-1:0] cnt_q;

  assign start_o = act_i && !act_q && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = zw_ni ? ST_EXEC : ST_ZWAIT;
      ST_EXEC:  state_d = ST_HOLD;
      ST_HOLD:  if (!act_i) state_d = ST_IDLE;
      ST_ZWAIT: if (!act_i) state_d = ST_ZBUSY;
      ST_ZBUSY: if (cnt_q == CW'(ZW_CYC - 1)) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_i;
      cnt_q   <= (state_q == ST_ZBUSY) ? cnt_q + 1'b1 : '0;
    end
  end

  assign exec_o  = (state_q == ST_EXEC) || ((state_q == ST_ZBUSY) && (cnt_q == '0));
  assign ready_o = (state_q == ST_HOLD) || (state_q == ST_ZBUSY);
  assign state_o = state_q;
endmodule

// File: rtl/hb_store.sv
module hb_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/hostbus_adapter.sv
module hostbus_adapter
  import hb_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RAW    = 3,
  parameter int ZW_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              strb_ni,
  input  logic              rw_i,
  input  logic              mem_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              ready_o,
  input  logic              wide_i,
  input  logic              pol_i,
  input  logic              bsel_i,
  input  logic              border_i,
  input  logic              zw_ni,
  input  logic              alat_transp_i
);
  localparam int RAM_DEPTH = 1 << AW;
  localparam int REG_DEPTH = 1 << RAW;

  logic      act;
  logic      start, exec;
  hb_state_e seq_state;
  logic      dec_read, dec_msb, dec_first;

  logic              read_q, msb_q, first_q, wide_q, mem_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] hold_q;

  logic [WORD_W-1:0] wr_word, rd_word, ram_rd, reg_rd;
  logic              commit, ram_we, reg_we, addr_ld;

  assign act = !sel_ni && !strb_ni;

  hb_decode u_dec (
    .wide_i  (wide_i),
    .pol_i   (pol_i),
    .border_i(border_i),
    .rw_i    (rw_i),
    .bsel_i  (bsel_i),
    .read_o  (dec_read),
    .msb_o   (dec_msb),
    .first_o (dec_first)
  );

  hb_seq #(.ZW_CYC(ZW_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .zw_ni  (zw_ni),
    .start_o(start),
    .exec_o (exec),
    .ready_o(ready_o),
    .state_o(seq_state)
  );

  // transparent latch keeps following the pins until the strobe is released
  assign addr_ld = start || (alat_transp_i && act && (seq_state == ST_ZWAIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_q  <= 1'b0;
      msb_q   <= 1'b0;
      first_q <= 1'b0;
      wide_q  <= 1'b1;
      mem_q   <= 1'b0;
      wdata_q <= '0;
      addr_q  <= '0;
    end else begin
      if (start) begin
        read_q  <= dec_read;
        msb_q   <= dec_msb;
        first_q <= dec_first;
        wide_q  <= wide_i;
        mem_q   <= mem_i;
        wdata_q <= wdata_i;
      end
      if (addr_ld) addr_q <= addr_i;
    end
  end

  assign wr_word = wide_q ? wdata_q :
                   msb_q  ? {wdata_q[BYTE_W-1:0], hold_q} : {hold_q, wdata_q[BYTE_W-1:0]};
  assign commit  = exec && !read_q && (wide_q || !first_q);
  assign ram_we  = commit && mem_q;
  assign reg_we  = commit && !mem_q;

  hb_store #(.DEPTH(RAM_DEPTH), .AW(AW), .DW(WORD_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .addr_i (addr_q),
    .wdata_i(wr_word),
    .rdata_o(ram_rd)
  );

  hb_store #(.DEPTH(REG_DEPTH), .AW(RAW), .DW(WORD_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .addr_i (addr_q[RAW-1:0]),
    .wdata_i(wr_word),
    .rdata_o(reg_rd)
  );

  assign rd_word = mem_q ? ram_rd : reg_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      hold_q  <= '0;
    end else if (exec) begin
      if (read_q) begin
        if (wide_q) begin
          rdata_q <= rd_word;
        end else if (first_q) begin
          rdata_q <= {{BYTE_W{1'b0}}, msb_q ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0]};
          hold_q  <= msb_q ? rd_word[BYTE_W-1:0] : rd_word[WORD_W-1:BYTE_W];
        end else begin
          rdata_q <= {{BYTE_W{1'b0}}, hold_q};
        end
      end else if (!wide_q && first_q) begin
        hold_q <= wdata_q[BYTE_W-1:0];
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/hb_checker.sv
module hb_checker
  import hb_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      sel_ni,
  input logic      strb_ni,
  input logic      zw_ni,
  input logic      ready_o,
  input hb_state_e state_i,
  input logic      start_i,
  input logic      exec_i,
  input logic      read_i,
  input logic      wide_i,
  input logic      first_i,
  input logic      ram_we_i,
  input logic      reg_we_i
);
  a_r1_idle_unselected_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_ni || strb_ni) && state_i == ST_IDLE) |=> !ready_o);

  a_r2_nz_ready_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && zw_ni) |=> !ready_o ##1 ready_o);

  a_r3_zw_no_ready_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZWAIT) |-> !ready_o);

  a_r3_zw_ready_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZWAIT && (sel_ni || strb_ni)) |=> ready_o);

  a_r8_first_byte_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !read_i && !wide_i && first_i) |-> !(ram_we_i || reg_we_i));

  a_r4_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_i && reg_we_i));

  always @(posedge clk_i) begin
    if (!rst_ni) a_r12_ready_low_in_reset: assert (!ready_o);
  end
endmodule

bind hostbus_adapter hb_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_ni  (sel_ni),
  .strb_ni (strb_ni),
  .zw_ni   (zw_ni),
  .ready_o (ready_o),
  .state_i (seq_state),
  .start_i (start),
  .exec_i  (exec),
  .read_i  (read_q),
  .wide_i  (wide_q),
  .first_i (first_q),
  .ram_we_i(ram_we),
  .reg_we_i(reg_we)
);

// File: tb/sim_hostbus_adapter.sv
module sim_hostbus_adapter;
  localparam int AW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ni = 1'b1, strb_ni = 1'b1, rw_i = 1'b0, mem_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic ready_o;
  logic wide_i = 1'b1, pol_i = 1'b1, bsel_i = 1'b0, border_i = 1'b0;
  logic zw_ni = 1'b1, alat_transp_i = 1'b0;

  int nchk = 0, nerr = 0;
  logic [15:0] got;
  logic [15:0] ram_m [64];
  logic [15:0] reg_m [8];

  always #10 clk_i = ~clk_i;

  hostbus_adapter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .strb_ni(strb_ni),
    .rw_i(rw_i), .mem_i(mem_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ready_o(ready_o), .wide_i(wide_i), .pol_i(pol_i),
    .bsel_i(bsel_i), .border_i(border_i), .zw_ni(zw_ni),
    .alat_transp_i(alat_transp_i)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wd, input logic pl, input logic bo, input logic zwn,
                           input logic al, input logic rw, input logic mm, input logic bs,
                           input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                           input logic [15:0] d, output logic [15:0] rd);
    int n;
    logic zbad;
    logic [2:0] rr;
    @(negedge clk_i);
    wide_i = wd; pol_i = pl; border_i = bo; zw_ni = zwn; alat_transp_i = al;
    rw_i = rw; mem_i = mm; bsel_i = bs; addr_i = a0; wdata_i = d;
    sel_ni = 1'b0; strb_ni = 1'b0;
    if (!zwn) begin
      zbad = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk_i);
        if (ready_o) zbad = 1'b1;
        if (i == 0) addr_i = a1;
      end
      sel_ni = 1'b1; strb_ni = 1'b1;
      chk("R3 ready low while strobed", {15'd0, zbad}, 16'd0);
      @(negedge clk_i); rr[2] = ready_o;
      @(negedge clk_i); rr[1] = ready_o;
      @(negedge clk_i); rr[0] = ready_o;
      rd = rdata_o;
      chk("R3 ready window after release", {13'd0, rr}, 16'b110);
    end else begin
      n = 0;
      do begin
        @(negedge clk_i);
        n++;
      end while (!ready_o && n < 10);
      rd = rdata_o;
      chk("R2 ready latency", 16'(n), 16'd2);
      sel_ni = 1'b1; strb_ni = 1'b1;
      @(negedge clk_i);
      chk("R2 ready falls after release", {15'd0, ready_o}, 16'd0);
    end
    @(negedge clk_i);
  endtask

  task automatic op16(input logic pl, input logic zwn, input logic bo, input logic al,
                      input logic wr, input logic mm, input logic [AW-1:0] a,
                      input logic [15:0] d, output logic [15:0] rd);
    bus_cycle(1'b1, pl, bo, zwn, al, pl ? !wr : wr, mm, 1'b0, a, a, d, rd);
  endtask

  task automatic op8(input logic pl, input logic bo, input logic zwn, input logic wr,
                     input logic mm, input logic msb, input logic [AW-1:0] a,
                     input logic [7:0] d, output logic [15:0] rd);
    bus_cycle(1'b0, pl, bo, zwn, 1'b0, !wr, mm, pl ? !msb : msb, a, a, {8'h00, d}, rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] v, nw, old;
    logic [AW-1:0] ra;
    logic pl, zwn, bo;
    logic sawrdy;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 ready after reset", {15'd0, ready_o}, 16'd0);
    chk("R12 rdata after reset", rdata_o, 16'h0000);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 16'h0, got);
    chk("R12 register reads zero", got, 16'h0000);

    // R1: select-only, then strobe-only, with a write set up
    sawrdy = 1'b0;
    wide_i = 1'b1; pol_i = 1'b1; rw_i = 1'b0; mem_i = 1'b0; addr_i = 6'd0;
    wdata_i = 16'hFFFF; zw_ni = 1'b1;
    sel_ni = 1'b0; strb_ni = 1'b1;
    repeat (4) begin @(negedge clk_i); if (ready_o) sawrdy = 1'b1; end
    sel_ni = 1'b1; strb_ni = 1'b0;
    repeat (4) begin @(negedge clk_i); if (ready_o) sawrdy = 1'b1; end
    strb_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 no ready with one strobe line", {15'd0, sawrdy}, 16'd0);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 16'h0, got);
    chk("R1 no write without both lines", got, 16'h0000);

    for (int k = 0; k < 64; k++) ram_m[k] = 16'h0;
    for (int k = 0; k < 8; k++) reg_m[k] = 16'h0;

    // word-mode sweep over polarity, timing and byte-order straps
    for (int cfg = 0; cfg < 8; cfg++) begin
      pl = cfg[0]; zwn = cfg[1]; bo = cfg[2];
      for (int a = 0; a < 8; a++) begin
        v = 16'(cfg * 16'h1111) ^ 16'(a * 16'h0203) ^ 16'hA5C3;
        op16(pl, zwn, bo, 1'b0, 1'b1, 1'b0, 6'(a), v, got);
        reg_m[a] = v;
        ra = 6'((a * 9 + cfg * 3) % 64);
        op16(pl, zwn, bo, 1'b0, 1'b1, 1'b1, ra, ~v, got);
        ram_m[ra] = ~v;
      end
      for (int a = 0; a < 8; a++) begin
        op16(pl, zwn, bo, 1'b0, 1'b0, 1'b0, 6'(a), 16'h0, got);
        chk("R5/R10 register readback", got, reg_m[a]);
        ra = 6'((a * 9 + cfg * 3) % 64);
        op16(pl, zwn, bo, 1'b0, 1'b0, 1'b1, ra, 16'h0, got);
        chk("R4 RAM readback distinct from registers", got, ram_m[ra]);
      end
    end

    // full RAM address sweep
    for (int a = 0; a < 64; a++) begin
      op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'(a), 16'(a * 16'h0405 + 16'h0011), got);
      ram_m[a] = 16'(a * 16'h0405 + 16'h0011);
    end
    for (int a = 0; a < 64; a++) begin
      op16(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'(a), 16'h0, got);
      chk("R4 RAM full sweep", got, ram_m[a]);
    end

    // byte mode
    for (int cfg = 0; cfg < 8; cfg++) begin
      pl = cfg[0]; bo = cfg[1]; zwn = cfg[2];
      ra = 6'(40 + cfg);
      old = 16'h1234 ^ 16'(cfg);
      nw = 16'hCA05 + 16'(cfg * 16'h0111);
      op16(pl, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ra, old, got);
      op8(pl, bo, zwn, 1'b1, 1'b1, bo, ra, bo ? nw[15:8] : nw[7:0], got);
      op16(pl, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ra, 16'h0, got);
      chk("R8 first byte write leaves word", got, old);
      op8(pl, bo, zwn, 1'b1, 1'b1, !bo, ra, bo ? nw[7:0] : nw[15:8], got);
      op16(pl, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ra, 16'h0, got);
      chk("R6/R7/R8 byte pair assembled", got, nw);
      op8(pl, bo, zwn, 1'b0, 1'b1, bo, ra, 8'h00, got);
      chk("R9/R13 first byte read", got, {8'h00, bo ? nw[15:8] : nw[7:0]});
      op16(pl, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ra, ~nw, got);
      op8(pl, bo, zwn, 1'b0, 1'b1, !bo, ra, 8'h00, got);
      chk("R9/R13 second byte from snapshot", got, {8'h00, bo ? nw[7:0] : nw[15:8]});
      op16(pl, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ra, 16'h0, got);
      chk("R9 intervening word write kept", got, ~nw);
    end

    // R11 address latch modes in zero-wait timing
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd50, 16'h0, got);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd51, 16'h0, got);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd52, 16'h0, got);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd53, 16'h0, got);
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd50, 6'd51, 16'h5050, got);
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd52, 6'd53, 16'h5353, got);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd50, 16'h0, got);
    chk("R11 edge latch uses start address", got, 16'h5050);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd51, 16'h0, got);
    chk("R11 edge latch ignores later address", got, 16'h0000);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd52, 16'h0, got);
    chk("R11 transparent latch leaves start address", got, 16'h0000);
    op16(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd53, 16'h0, got);
    chk("R11 transparent latch uses last address", got, 16'h5353);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule